// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block is the receive half of a descriptor-driven Ethernet DMA. Software builds a ring of descriptors in a small descriptor memory, starting at a ring base address. Each descriptor names a byte buffer and carries an ownership flag: while the flag reads "empty", the descriptor belongs to hardware. The engine fetches the descriptor at its current ring position. If that descriptor is empty, the engine stores the next incoming frame byte by byte into its buffer. When the frame ends, the engine writes the descriptor back with the received length, the error bits and the ownership flag cleared, and then moves to the next ring position.

Frames arrive on a byte stream that has a valid strobe and start, end and error markers. There is no backpressure. A frame that arrives while the current descriptor still belongs to software raises a busy event, and the engine halts. The engine also leaves reset halted. A one-cycle halt-clear pulse restarts it at the same ring position. The two events are sticky and are cleared by writing 1. A stop request lets the engine finish the frame it is storing, write that frame back, and raise a stop-complete event. The engine then stores nothing until the request is withdrawn.

States: HALT (reset, or busy), FETCH (read the descriptor), CHECK (test the ownership flag), READY (waiting for a start marker), POLL (descriptor not yet returned: re-read it every cycle), RECV (storing bytes), WBACK (descriptor write-back and ring advance), DROP (discarding the rest of a frame that began while halted or stopped), GSTOP (stopped on request).

Transitions:
- HALT to FETCH or DROP on halt-clear.
- FETCH to CHECK.
- CHECK to READY if the descriptor is empty, otherwise to POLL.
- POLL to HALT on a start marker, to GSTOP on a stop request, or to READY once a read returns an empty descriptor.
- READY to GSTOP on a stop request, or on a start marker to RECV (to WBACK if the same byte also ends the frame).
- RECV to WBACK on the end marker.
- WBACK to GSTOP on a stop request, otherwise to FETCH.
- GSTOP to FETCH or DROP when the request drops.
- DROP to FETCH on the end marker.

Top module: `rxd_engine`

## Requirements
- R1: After reset the engine is halted, both events read 0, and it issues no descriptor read, descriptor write or buffer write. It leaves the halt on a halt-clear pulse.
- R2: A frame that starts while the current descriptor is empty is written byte by byte, in arrival order, to buffer addresses ptr, ptr+1, and so on.
- R3: The write-back word has the empty bit (bit 31) at 0. Wrap (bit 30) and the buffer pointer (bits 15:0) keep their fetched values. Length (bits 27:16) is the count of all frame bytes, FCS included.
- R4: The frame-error bit (bit 28) is 1 if the error marker appeared on any byte of the frame. A frame with the error marker never asserted and no truncation gets bits 29:28 both 0.
- R5: When a frame is longer than max_len, the bytes past max_len are not written, the stored length equals max_len, and the length-error bit (bit 29) is 1.
- R6: After a write-back the engine uses the descriptor at ring_base+idx+1. If the wrap bit was set, it uses the descriptor at ring_base instead.
- R7: A frame whose start arrives while the current descriptor is not empty sets ev_busy and halts the engine. None of its bytes are stored, and the descriptor is left unchanged.
- R8: A frame that starts while the engine is halted or stopped is dropped whole. If the halt is cleared in the middle of such a frame, the rest of that frame is dropped too.
- R9: Writing 1 to ev_busy_w1c clears ev_busy and does not end the halt. After halt_clr, the next frame goes to the descriptor that was refused.
- R10: If stop_req is raised during a frame, that frame is completed and written back, and then ev_gsc rises. Frames that arrive while stopped are not stored. Writing 1 to ev_gsc_w1c clears ev_gsc. Dropping stop_req resumes reception.
- R11: While no frame arrives, a descriptor that is not empty is re-read until it becomes empty. The next frame is then stored in it without a busy event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ring_base | input | DESC_AW | Descriptor memory address of ring entry 0 |
| max_len | input | 12 | Largest number of bytes stored per frame |
| stop_req | input | 1 | Level request for a stop after the current frame |
| halt_clr | input | 1 | Pulse that leaves the halted state |
| ev_busy_w1c | input | 1 | Write-1 clear of the busy event |
| ev_gsc_w1c | input | 1 | Write-1 clear of the stop-complete event |
| rx_valid | input | 1 | Stream byte valid |
| rx_data | input | BYTE_W | Stream byte |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | Error marker for this byte |
| desc_addr | output | DESC_AW | Descriptor memory address |
| desc_rd | output | 1 | Descriptor read strobe; the data is returned one cycle later |
| desc_rdata | input | 32 | Descriptor read data |
| desc_wr | output | 1 | Descriptor write strobe |
| desc_wdata | output | 32 | Descriptor write data |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 16 | Buffer byte address |
| buf_wdata | output | BYTE_W | Buffer byte data |
| ev_busy | output | 1 | Sticky busy event |
| ev_gsc | output | 1 | Sticky stop-complete event |
| rx_halted | output | 1 | Engine is halted |

## Verification
The assertions take the following for granted about the inputs:
- The descriptor memory answers a read in the following cycle.
- The stream is well formed: every start marker is followed by an end marker before the next start.
- At least four idle cycles follow each end marker, so the next descriptor is fetched and checked before the next frame starts.
- max_len and ring_base do not change while a frame is in flight.

The bench's frame task always leaves an eight-cycle gap after each frame. It changes max_len only between frames, and its memory model has the one-cycle read latency. Frame lengths, error positions and data are drawn at random from a fixed seed. Single-byte, exact-limit and over-limit frames, mid-frame halt-clear and mid-frame stop are driven directly.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
    localparam int LEN_W  = 12;
    localparam int PTR_W  = 16;
    localparam int DESC_W = 4 + LEN_W + PTR_W;

    typedef struct packed {
        logic             empty;
        logic             wrap;
        logic             len_err;
        logic             frm_err;
        logic [LEN_W-1:0] len;
        logic [PTR_W-1:0] ptr;
    } rxd_desc_t;

    typedef enum logic [3:0] {
        ST_HALT, ST_FETCH, ST_CHECK, ST_READY, ST_POLL,
        ST_RECV, ST_WBACK, ST_DROP, ST_GSTOP
    } rxd_state_t;
endpackage

// File: rtl/rxd_track.sv
module rxd_track (
    input  logic clk,
    input  logic rst_n,
    input  logic beat,
    input  logic sof,
    input  logic eof,
    output logic open_next
);
    logic open_q;

    always_comb begin
        open_next = open_q;
        if (beat && sof && !eof) open_next = 1'b1;
        else if (beat && eof)    open_next = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) open_q <= 1'b0;
        else        open_q <= open_next;
    end
endmodule

// File: rtl/rxd_fill.sv
module rxd_fill #(
    parameter int LEN_W  = 12,
    parameter int PTR_W  = 16,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              take,
    input  logic [LEN_W-1:0]  max_len,
    input  logic [PTR_W-1:0]  ptr,
    input  logic [BYTE_W-1:0] rx_data,
    input  logic              rx_err,
    output logic              buf_we,
    output logic [PTR_W-1:0]  buf_addr,
    output logic [BYTE_W-1:0] buf_wdata,
    output logic [LEN_W-1:0]  count,
    output logic              len_err,
    output logic              frm_err
);
    logic room;
    logic zero_lim;

    assign zero_lim  = (max_len == '0);
    assign room      = (count < max_len);
    assign buf_we    = (start && !zero_lim) || (take && room);
    assign buf_addr  = start ? ptr : ptr + PTR_W'(count);
    assign buf_wdata = rx_data;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count   <= '0;
            len_err <= 1'b0;
            frm_err <= 1'b0;
        end else if (start) begin
            count   <= zero_lim ? '0 : LEN_W'(1);
            len_err <= zero_lim;
            frm_err <= rx_err;
        end else if (take) begin
            if (room) count   <= count + 1'b1;
            else      len_err <= 1'b1;
            frm_err <= frm_err | rx_err;
        end
    end
endmodule

// File: rtl/rxd_events.sv
module rxd_events (
    input  logic clk,
    input  logic rst_n,
    input  logic busy_set,
    input  logic busy_w1c,
    input  logic gsc_set,
    input  logic gsc_w1c,
    output logic ev_busy,
    output logic ev_gsc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_busy <= 1'b0;
            ev_gsc  <= 1'b0;
        end else begin
            if (busy_set)      ev_busy <= 1'b1;
            else if (busy_w1c) ev_busy <= 1'b0;
            if (gsc_set)       ev_gsc  <= 1'b1;
            else if (gsc_w1c)  ev_gsc  <= 1'b0;
        end
    end
endmodule

// File: rtl/rxd_fsm.sv
module rxd_fsm
    import rxd_pkg::*;
#(
    parameter int DESC_AW = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DESC_AW-1:0] ring_base,
    input  logic               stop_req,
    input  logic               halt_clr,
    input  logic               beat,
    input  logic               sof,
    input  logic               eof,
    input  logic               open_next,
    input  logic [DESC_W-1:0]  desc_rdata,
    input  logic [LEN_W-1:0]   fill_len,
    input  logic               fill_lerr,
    input  logic               fill_ferr,
    output logic [DESC_AW-1:0] desc_addr,
    output logic               desc_rd,
    output logic               desc_wr,
    output logic [DESC_W-1:0]  desc_wdata,
    output logic               start,
    output logic               take,
    output logic [PTR_W-1:0]   cur_ptr,
    output logic               busy_set,
    output logic               gsc_set,
    output logic               halted
);
    rxd_state_t         state, nxt;
    rxd_desc_t          rdesc, wdesc;
    logic [DESC_AW-1:0] idx;
    logic               rd_vld;
    logic               q_wrap;
    logic [PTR_W-1:0]   q_ptr;
    logic               sof_b;

    assign rdesc = rxd_desc_t'(desc_rdata);
    assign sof_b = beat && sof;

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_HALT:  if (halt_clr) nxt = open_next ? ST_DROP : ST_FETCH;
            ST_FETCH: nxt = ST_CHECK;
            ST_CHECK: nxt = rdesc.empty ? ST_READY : ST_POLL;
            ST_POLL: begin
                if (sof_b)                      nxt = ST_HALT;
                else if (stop_req)              nxt = ST_GSTOP;
                else if (rd_vld && rdesc.empty) nxt = ST_READY;
            end
            ST_READY: begin
                if (stop_req)   nxt = ST_GSTOP;
                else if (sof_b) nxt = eof ? ST_WBACK : ST_RECV;
            end
            ST_RECV:  if (beat && eof) nxt = ST_WBACK;
            ST_WBACK: nxt = stop_req ? ST_GSTOP : ST_FETCH;
            ST_GSTOP: if (!stop_req) nxt = open_next ? ST_DROP : ST_FETCH;
            ST_DROP:  if (beat && eof) nxt = ST_FETCH;
            default:  nxt = ST_HALT;
        endcase
    end

    // state and ring registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_HALT;
            idx    <= '0;
            rd_vld <= 1'b0;
            q_wrap <= 1'b0;
            q_ptr  <= '0;
        end else begin
            state  <= nxt;
            rd_vld <= desc_rd;
            if (state == ST_CHECK || (state == ST_POLL && rd_vld)) begin
                q_wrap <= rdesc.wrap;
                q_ptr  <= rdesc.ptr;
            end
            if (state == ST_WBACK)
                idx <= q_wrap ? '0 : idx + 1'b1;
        end
    end

    // outputs
    always_comb begin
        desc_rd  = 1'b0;
        desc_wr  = 1'b0;
        start    = 1'b0;
        take     = 1'b0;
        busy_set = 1'b0;
        gsc_set  = 1'b0;
        halted   = 1'b0;
        unique case (state)
            ST_HALT:  halted = 1'b1;
            ST_FETCH: desc_rd = 1'b1;
            ST_POLL: begin
                desc_rd  = 1'b1;
                busy_set = sof_b;
                gsc_set  = !sof_b && stop_req;
            end
            ST_READY: begin
                gsc_set = stop_req;
                start   = !stop_req && sof_b;
            end
            ST_RECV:  take = beat;
            ST_WBACK: begin
                desc_wr = 1'b1;
                gsc_set = stop_req;
            end
            default: ;
        endcase
    end

    always_comb begin
        wdesc.empty   = 1'b0;
        wdesc.wrap    = q_wrap;
        wdesc.len_err = fill_lerr;
        wdesc.frm_err = fill_ferr;
        wdesc.len     = fill_len;
        wdesc.ptr     = q_ptr;
    end

    assign desc_wdata = wdesc;
    assign desc_addr  = ring_base + idx;
    assign cur_ptr    = q_ptr;
endmodule

// File: rtl/rxd_engine.sv
module rxd_engine
    import rxd_pkg::*;
#(
    parameter int DESC_AW = 8,
    parameter int BYTE_W  = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [DESC_AW-1:0] ring_base,
    input  logic [LEN_W-1:0]   max_len,
    input  logic               stop_req,
    input  logic               halt_clr,
    input  logic               ev_busy_w1c,
    input  logic               ev_gsc_w1c,
    input  logic               rx_valid,
    input  logic [BYTE_W-1:0]  rx_data,
    input  logic               rx_sof,
    input  logic               rx_eof,
    input  logic               rx_err,
    output logic [DESC_AW-1:0] desc_addr,
    output logic               desc_rd,
    input  logic [DESC_W-1:0]  desc_rdata,
    output logic               desc_wr,
    output logic [DESC_W-1:0]  desc_wdata,
    output logic               buf_we,
    output logic [PTR_W-1:0]   buf_addr,
    output logic [BYTE_W-1:0]  buf_wdata,
    output logic               ev_busy,
    output logic               ev_gsc,
    output logic               rx_halted
);
    logic             open_next;
    logic             start, take, busy_set, gsc_set;
    logic [PTR_W-1:0] cur_ptr;
    logic [LEN_W-1:0] fill_len;
    logic             fill_lerr, fill_ferr;

    rxd_track u_track (
        .clk(clk), .rst_n(rst_n), .beat(rx_valid), .sof(rx_sof),
        .eof(rx_eof), .open_next(open_next)
    );

    rxd_fsm #(.DESC_AW(DESC_AW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base),
        .stop_req(stop_req), .halt_clr(halt_clr), .beat(rx_valid),
        .sof(rx_sof), .eof(rx_eof), .open_next(open_next),
        .desc_rdata(desc_rdata), .fill_len(fill_len),
        .fill_lerr(fill_lerr), .fill_ferr(fill_ferr),
        .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_wr(desc_wr),
        .desc_wdata(desc_wdata), .start(start), .take(take),
        .cur_ptr(cur_ptr), .busy_set(busy_set), .gsc_set(gsc_set),
        .halted(rx_halted)
    );

    rxd_fill #(.LEN_W(LEN_W), .PTR_W(PTR_W), .BYTE_W(BYTE_W)) u_fill (
        .clk(clk), .rst_n(rst_n), .start(start), .take(take),
        .max_len(max_len), .ptr(cur_ptr), .rx_data(rx_data),
        .rx_err(rx_err), .buf_we(buf_we), .buf_addr(buf_addr),
        .buf_wdata(buf_wdata), .count(fill_len), .len_err(fill_lerr),
        .frm_err(fill_ferr)
    );

    rxd_events u_events (
        .clk(clk), .rst_n(rst_n), .busy_set(busy_set),
        .busy_w1c(ev_busy_w1c), .gsc_set(gsc_set), .gsc_w1c(ev_gsc_w1c),
        .ev_busy(ev_busy), .ev_gsc(ev_gsc)
    );
endmodule

// File: rtl/rxd_engine_chk.sv
module rxd_engine_chk
    import rxd_pkg::*;
#(
    parameter int DESC_AW = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic [DESC_AW-1:0] ring_base,
    input logic [LEN_W-1:0]   max_len,
    input logic               stop_req,
    input logic [DESC_AW-1:0] desc_addr,
    input logic               desc_rd,
    input logic               desc_wr,
    input logic [DESC_W-1:0]  desc_wdata,
    input logic               buf_we,
    input logic               ev_busy,
    input logic               ev_gsc,
    input logic               rx_halted
);
    rxd_desc_t wd;
    assign wd = rxd_desc_t'(desc_wdata);

    a_r1_port_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(desc_rd && desc_wr));

    a_r5_len_capped: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr |-> wd.len <= max_len);

    a_r5_lerr_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr && wd.len_err |-> wd.len == max_len);

    a_r6_wrap_to_base: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr && wd.wrap |=> desc_addr == ring_base);

    a_r6_fetch_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
        desc_wr && !stop_req |=> desc_rd);

    a_r7_busy_halts: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_busy) |-> rx_halted);

    a_r8_no_store_halted: assert property (@(posedge clk) disable iff (!rst_n)
        rx_halted |-> !buf_we);

    a_r10_gsc_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ev_gsc) |-> !buf_we && !desc_wr);
endmodule

bind rxd_engine rxd_engine_chk #(.DESC_AW(DESC_AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_len(max_len),
    .stop_req(stop_req), .desc_addr(desc_addr), .desc_rd(desc_rd),
    .desc_wr(desc_wr), .desc_wdata(desc_wdata), .buf_we(buf_we),
    .ev_busy(ev_busy), .ev_gsc(ev_gsc), .rx_halted(rx_halted)
);

// File: tb/rxd_engine_test.sv
module rxd_engine_test;
    localparam int CLK_NS = 10;
    localparam int AW     = 8;
    localparam int BASE   = 16;
    localparam int RING   = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] ring_base = AW'(BASE);
    logic [11:0]   max_len = 12'd64;
    logic          stop_req = 0, halt_clr = 0, ev_busy_w1c = 0, ev_gsc_w1c = 0;
    logic          rx_valid = 0, rx_sof = 0, rx_eof = 0, rx_err = 0;
    logic [7:0]    rx_data = 0;
    logic [AW-1:0] desc_addr;
    logic          desc_rd, desc_wr, buf_we, ev_busy, ev_gsc, rx_halted;
    logic [31:0]   desc_rdata = 0, desc_wdata;
    logic [15:0]   buf_addr;
    logic [7:0]    buf_wdata;

    rxd_engine uut (
        .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .max_len(max_len),
        .stop_req(stop_req), .halt_clr(halt_clr), .ev_busy_w1c(ev_busy_w1c),
        .ev_gsc_w1c(ev_gsc_w1c), .rx_valid(rx_valid), .rx_data(rx_data),
        .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .desc_addr(desc_addr), .desc_rd(desc_rd), .desc_rdata(desc_rdata),
        .desc_wr(desc_wr), .desc_wdata(desc_wdata), .buf_we(buf_we),
        .buf_addr(buf_addr), .buf_wdata(buf_wdata), .ev_busy(ev_busy),
        .ev_gsc(ev_gsc), .rx_halted(rx_halted)
    );

    always #(CLK_NS/2) clk = ~clk;

    logic [31:0] dmem [0:(1<<AW)-1];
    logic [7:0]  bmem [0:4095];
    int          nwr = 0;
    int          tests = 0, fails = 0;
    bit          done = 0;
    logic [7:0]  fb [0:255];

    always @(posedge clk) begin
        if (desc_rd) desc_rdata <= dmem[desc_addr];
        if (desc_wr) dmem[desc_addr] <= desc_wdata;
        if (buf_we) begin
            bmem[buf_addr[11:0]] <= buf_wdata;
            nwr <= nwr + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] ptr_of(input int i);
        return 16'(16'h0100 * (i + 1));
    endfunction

    function automatic logic [31:0] exp_desc(input int i, input int n, input int maxl, input int errpos);
        logic [11:0] len;
        len = (n > maxl) ? 12'(maxl) : 12'(n);
        return {1'b0, (i == RING-1), (n > maxl), (errpos >= 0 && errpos < n), len, ptr_of(i)};
    endfunction

    task automatic arm(input int i);
        dmem[BASE+i] = {1'b1, (i == RING-1), 2'b00, 12'h000, ptr_of(i)};
        for (int k = 0; k < 300; k++) bmem[(int'(ptr_of(i)) + k) & 4095] = 8'hEE;
    endtask

    task automatic disarm(input int i);
        dmem[BASE+i] = {1'b0, (i == RING-1), 2'b00, 12'h000, ptr_of(i)};
    endtask

    task automatic send_frame(input int n, input int errpos, input int stop_at, input int clr_at);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            fb[k]    = 8'($urandom);
            rx_valid = 1; rx_data = fb[k];
            rx_sof = (k == 0); rx_eof = (k == n-1); rx_err = (k == errpos);
            halt_clr = (k == clr_at);
            if (k == stop_at) stop_req = 1;
        end
        @(negedge clk);
        rx_valid = 0; rx_sof = 0; rx_eof = 0; rx_err = 0; halt_clr = 0;
        repeat (8) @(negedge clk);
    endtask

    task automatic check_frame(input int i, input int n, input int maxl, input int errpos);
        int lim, bad;
        chk(dmem[BASE+i] == exp_desc(i, n, maxl, errpos), "R3 R4 R6 descriptor write-back",
            dmem[BASE+i], exp_desc(i, n, maxl, errpos));
        lim = (n > maxl) ? maxl : n;
        bad = 0;
        for (int k = 0; k < lim; k++)
            if (bmem[(int'(ptr_of(i)) + k) & 4095] != fb[k]) bad++;
        chk(bad == 0, "R2 buffer bytes", bad, 0);
        if (n > maxl)
            chk(bmem[(int'(ptr_of(i)) + maxl) & 4095] == 8'hEE, "R5 no write past limit",
                bmem[(int'(ptr_of(i)) + maxl) & 4095], 8'hEE);
    endtask

    task automatic pulse(ref logic s);
        @(negedge clk); s = 1; @(negedge clk); s = 0;
    endtask

    int eidx = 0;
    int snap;

    task automatic frame_ok(input int n, input int errpos);
        send_frame(n, errpos, -1, -1);
        check_frame(eidx, n, int'(max_len), errpos);
        arm(eidx);
        eidx = (eidx + 1) % RING;
    endtask

    initial begin
        void'($urandom(32'h5eed_0042));
        for (int k = 0; k < (1<<AW); k++) dmem[k] = '0;
        for (int k = 0; k < 4096; k++) bmem[k] = 8'hEE;
        for (int i = 0; i < RING; i++) arm(i);
        repeat (3) @(negedge clk);
        rst_n = 1;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(rx_halted == 1, "R1 halted after reset", rx_halted, 1);
        chk(ev_busy == 0 && ev_gsc == 0, "R1 events clear", {ev_busy, ev_gsc}, 0);
        chk(!desc_rd && !desc_wr && !buf_we, "R1 no memory activity", {desc_rd, desc_wr, buf_we}, 0);
        // R8 frame while halted is dropped
        send_frame(20, -1, -1, -1);
        chk(nwr == 0, "R8 no store while halted", nwr, 0);
        chk(dmem[BASE][31] == 1, "R8 descriptor untouched", dmem[BASE][31], 1);
        pulse(halt_clr);
        repeat (5) @(negedge clk);
        chk(rx_halted == 0, "R1 leaves halt on clear", rx_halted, 0);
        // directed: single byte, exact limit, then random frames (R2 R3 R4 R6)
        frame_ok(1, -1);
        frame_ok(64, -1);
        for (int f = 0; f < 12; f++) begin
            int n, ep;
            n  = 1 + int'($urandom % 48);
            ep = ($urandom % 4 == 0) ? int'($urandom % n) : -1;
            frame_ok(n, ep);
        end
        // R5 truncation with error on a dropped byte
        max_len = 12'd10;
        repeat (2) @(negedge clk);
        frame_ok(15, 12);
        max_len = 12'd64;
        // R11 polling a returned descriptor
        disarm((eidx + 1) % RING);
        frame_ok(9, -1);
        snap = nwr;
        repeat (12) @(negedge clk);
        chk(nwr == snap && ev_busy == 0, "R11 idle while not empty", nwr - snap, 0);
        arm(eidx);
        repeat (5) @(negedge clk);
        frame_ok(11, -1);
        chk(ev_busy == 0, "R11 no busy after return", ev_busy, 0);
        // R7 busy
        disarm((eidx + 1) % RING);
        frame_ok(7, -1);
        repeat (4) @(negedge clk);
        snap = nwr;
        send_frame(13, -1, -1, -1);
        chk(ev_busy == 1 && rx_halted == 1, "R7 busy and halted", {ev_busy, rx_halted}, 3);
        chk(nwr == snap, "R7 frame not stored", nwr - snap, 0);
        chk(dmem[BASE+eidx][31] == 0, "R7 descriptor unchanged", dmem[BASE+eidx][31], 0);
        pulse(ev_busy_w1c);
        chk(ev_busy == 0 && rx_halted == 1, "R9 w1c clears busy, halt stays", {ev_busy, rx_halted}, 1);
        // R8 halt cleared mid-frame: remainder dropped
        arm(eidx);
        snap = nwr;
        send_frame(12, -1, -1, 5);
        chk(nwr == snap, "R8 mid-frame resume drops frame", nwr - snap, 0);
        chk(dmem[BASE+eidx][31] == 1, "R8 descriptor still empty", dmem[BASE+eidx][31], 1);
        frame_ok(10, 3);  // R9 lands in the refused descriptor
        // R10 graceful stop during a frame
        send_frame(20, -1, 8, -1);
        check_frame(eidx, 20, 64, -1);
        chk(ev_gsc == 1, "R10 stop-complete raised", ev_gsc, 1);
        arm(eidx);
        eidx = (eidx + 1) % RING;
        snap = nwr;
        send_frame(10, -1, -1, -1);
        chk(nwr == snap, "R10 no store while stopped", nwr - snap, 0);
        pulse(ev_gsc_w1c);
        chk(ev_gsc == 0, "R10 w1c clears stop-complete", ev_gsc, 0);
        stop_req = 0;
        repeat (5) @(negedge clk);
        frame_ok(17, -1);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++; fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule